// File: doc/BRIEF.md
# Table Address Walker

The walker turns an entry index, such as a device number, into the physical address of that entry's storage in a translation table. The table is described by decoded base-descriptor fields: a valid flag, a flat-or-two-level selector, a page-size code, the entry size minus one, the page count minus one, and the 36-bit base field that stands for address bits [47:12]. A request is accepted with a valid/ready handshake. The block answers with a one-cycle done pulse that carries a 52-bit address and a fault code.

For a flat table the address is pure arithmetic, and the result comes one cycle after the request is accepted. For a two-level table the block first reads one 64-bit little-endian first-level descriptor through a request/response memory port. It keeps only one read outstanding. It then adds the entry's offset inside the page that the descriptor points to. Out-of-range indices and invalid tables or descriptors are reported as faults instead of addresses.

Top module: `table_walker`

## Requirements
- R1: During and right after reset, `reqReady` is 1, and `doneValid` and `memReqValid` are both 0.
- R2: For page-size code 0 (4 KB) and code 1 (16 KB), the table base is `{cfgBaseField, 12'b0}` with every bit below the page size cleared, and base bits [51:48] are zero.
- R3: For page-size code 2 (64 KB), and for code 3, which is treated as 64 KB, base bits [47:16] are `cfgBaseField[35:4]`, base bits [51:48] are `cfgBaseField[3:0]`, and base bits [15:0] are zero.
- R4: Flat mode (`cfgIndirect`=0) uses entry bytes E=`cfgEntrySizeM1`+1. When `index*E` is less than (`cfgPagesM1`+1)*pageBytes, `doneValid` pulses in the cycle after acceptance with `doneAddr`=base+`index*E` and `doneFault`=0. Fault codes are: 0 none, 1 out of range, 2 invalid. Code 3 never appears.
- R5: In flat mode, when `index*E` is at least (`cfgPagesM1`+1)*pageBytes, the done pulse comes in the cycle after acceptance with `doneFault`=1. Every faulted result has `doneAddr`=0.
- R6: A request accepted with `cfgValid`=0 completes in the next cycle with `doneFault`=2, `doneAddr`=0, and no memory request.
- R7: In two-level mode with P=floor(pageBytes/E), the block requests the descriptor at base+8*floor(index/P). This address is always 8-byte aligned. `memReqValid` and `memReqAddr` stay steady until `memReqReady`. `reqReady` is 0 while the walk is in progress.
- R8: When a two-level response has bit 63 set, `doneValid` pulses in the cycle after `memRspValid`. `doneAddr` is (`memRspData[51:0]` with the bits below the page size cleared) + (index mod P)*E, and `doneFault`=0. The configuration is captured at acceptance.
- R9: When a two-level response has bit 63 clear, the walk completes in the next cycle with `doneFault`=2 and `doneAddr`=0.
- R10: In two-level mode, when floor(index/P)*8 is at least (`cfgPagesM1`+1)*pageBytes, the walk completes in the cycle after acceptance with `doneFault`=1 and issues no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqIndex | input | IDX_W | Entry index to translate |
| cfgValid | input | 1 | Table has memory allocated |
| cfgIndirect | input | 1 | 1 selects a two-level table |
| cfgPageSize | input | 2 | 0: 4 KB, 1: 16 KB, 2 or 3: 64 KB |
| cfgEntrySizeM1 | input | 5 | Bytes per entry minus one |
| cfgPagesM1 | input | 8 | Allocated pages minus one |
| cfgBaseField | input | 36 | Base field, register bits [47:12] |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 52 | Descriptor address |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Descriptor; bit 63 valid, bits [51:0] page address |
| doneValid | output | 1 | Result pulse |
| doneAddr | output | 52 | Entry address, 0 on fault |
| doneFault | output | 2 | 0 none, 1 out of range, 2 invalid |

## Verification
A wrong control state has a visible symptom at the ports. A walker that does not return to idle keeps `reqReady` low. A walker stuck in the fetch state leaves `memReqValid` high after the handshake, and the bench sees either one at the first sampling point after that edge. Errors in the captured offset, mask or descriptor address show up only when a walk completes: as a wrong `memReqAddr` one cycle after acceptance, or as a wrong `doneAddr` one cycle after the response. The bench therefore changes the configuration inputs right after each acceptance, so that a block that fails to capture its configuration gives a wrong result on that same walk.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int PA_W   = 52;
  localparam int DESC_W = 64;
  localparam int WIDE   = 64;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_RANGE   = 2'd1,
    FLT_INVALID = 2'd2
  } twFault_e;

  typedef struct packed {
    logic     capture;   // latch per-walk state from the request
    logic     finish;    // register a result this cycle
    logic     fromDesc;  // result uses the descriptor path
    twFault_e fault;
  } twStrobe_t;
endpackage

// File: rtl/tw_datapath.sv
module tw_datapath
  import tw_pkg::*;
#(
  parameter int IDX_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  twStrobe_t         strobe,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [1:0]        cfgPageSize,
  input  logic [4:0]        cfgEntrySizeM1,
  input  logic [7:0]        cfgPagesM1,
  input  logic [35:0]       cfgBaseField,
  input  logic [DESC_W-1:0] memRspData,
  output logic              flatInRange,
  output logic              slotInRange,
  output logic              descValid,
  output logic [PA_W-1:0]   memReqAddr,
  output logic              doneValid,
  output logic [PA_W-1:0]   doneAddr,
  output twFault_e          doneFault
);
  logic [4:0]      pageShift;
  logic [WIDE-1:0] pageBytes, pageMask, entryBytes, tableBytes, indexWide;
  logic [WIDE-1:0] flatOffset, perPage, slotNum, slotRem, remOffset;
  logic [47:0]     regView;
  logic [3:0]      hiBits;
  logic [PA_W-1:0] tableBase, flatAddr, descAddrNext;
  logic [PA_W-1:0] descAddrQ, remOffsetQ, descMaskQ, descPage, descFinal;

  always_comb begin
    case (cfgPageSize)
      2'b00:   pageShift = 5'd12;
      2'b01:   pageShift = 5'd14;
      default: pageShift = 5'd16;
    endcase
  end

  assign pageBytes  = WIDE'(1) << pageShift;
  assign pageMask   = ~(pageBytes - WIDE'(1));
  assign regView    = {cfgBaseField, 12'b0};
  assign hiBits     = (pageShift == 5'd16) ? cfgBaseField[3:0] : 4'b0;
  assign tableBase  = {hiBits, regView & pageMask[47:0]};
  assign entryBytes = WIDE'(cfgEntrySizeM1) + WIDE'(1);
  assign tableBytes = (WIDE'(cfgPagesM1) + WIDE'(1)) << pageShift;
  assign indexWide  = WIDE'(reqIndex);

  // flat geometry
  assign flatOffset  = indexWide * entryBytes;
  assign flatInRange = flatOffset < tableBytes;
  assign flatAddr    = tableBase + flatOffset[PA_W-1:0];

  // two-level geometry
  assign perPage      = pageBytes / entryBytes;
  assign slotNum      = indexWide / perPage;
  assign slotRem      = indexWide % perPage;
  assign slotInRange  = slotNum < (tableBytes >> 3);
  assign descAddrNext = tableBase + PA_W'(slotNum << 3);
  assign remOffset    = slotRem * entryBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddrQ  <= '0;
      remOffsetQ <= '0;
      descMaskQ  <= '0;
    end else if (strobe.capture) begin
      descAddrQ  <= descAddrNext;
      remOffsetQ <= remOffset[PA_W-1:0];
      descMaskQ  <= pageMask[PA_W-1:0];
    end
  end

  assign memReqAddr = descAddrQ;
  assign descValid  = memRspData[DESC_W-1];
  assign descPage   = memRspData[PA_W-1:0] & descMaskQ;
  assign descFinal  = descPage + remOffsetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneAddr  <= '0;
      doneFault <= FLT_NONE;
    end else begin
      doneValid <= strobe.finish;
      if (strobe.finish) begin
        doneFault <= strobe.fault;
        if (strobe.fault != FLT_NONE) doneAddr <= '0;
        else if (strobe.fromDesc)     doneAddr <= descFinal;
        else                          doneAddr <= flatAddr;
      end
    end
  end
endmodule

// File: rtl/tw_control.sv
module tw_control
  import tw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      cfgValid,
  input  logic      cfgIndirect,
  input  logic      flatInRange,
  input  logic      slotInRange,
  input  logic      descValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output logic      reqReady,
  output logic      memReqValid,
  output twStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} twState_e;
  twState_e state, stateNext;

  always_comb begin
    stateNext       = state;
    strobe          = '0;
    strobe.fault    = FLT_NONE;
    reqReady        = (state == ST_IDLE);
    memReqValid     = (state == ST_FETCH);
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        if (!cfgValid) begin
          strobe.finish = 1'b1;
          strobe.fault  = FLT_INVALID;
        end else if (!cfgIndirect) begin
          strobe.finish = 1'b1;
          strobe.fault  = flatInRange ? FLT_NONE : FLT_RANGE;
        end else if (!slotInRange) begin
          strobe.finish = 1'b1;
          strobe.fault  = FLT_RANGE;
        end else begin
          stateNext = ST_FETCH;
        end
      end
      ST_FETCH: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) begin
        strobe.finish   = 1'b1;
        strobe.fromDesc = 1'b1;
        strobe.fault    = descValid ? FLT_NONE : FLT_INVALID;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/table_walker.sv
module table_walker
  import tw_pkg::*;
#(
  parameter int IDX_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic              cfgValid,
  input  logic              cfgIndirect,
  input  logic [1:0]        cfgPageSize,
  input  logic [4:0]        cfgEntrySizeM1,
  input  logic [7:0]        cfgPagesM1,
  input  logic [35:0]       cfgBaseField,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [51:0]       memReqAddr,
  input  logic              memRspValid,
  input  logic [63:0]       memRspData,
  output logic              doneValid,
  output logic [51:0]       doneAddr,
  output logic [1:0]        doneFault
);
  twStrobe_t strobe;
  twFault_e  faultOut;
  logic      flatInRange, slotInRange, descValid;

  tw_control ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgValid(cfgValid),
    .cfgIndirect(cfgIndirect), .flatInRange(flatInRange),
    .slotInRange(slotInRange), .descValid(descValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .reqReady(reqReady), .memReqValid(memReqValid), .strobe(strobe)
  );

  tw_datapath #(.IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIndex(reqIndex),
    .cfgPageSize(cfgPageSize), .cfgEntrySizeM1(cfgEntrySizeM1),
    .cfgPagesM1(cfgPagesM1), .cfgBaseField(cfgBaseField),
    .memRspData(memRspData), .flatInRange(flatInRange),
    .slotInRange(slotInRange), .descValid(descValid),
    .memReqAddr(memReqAddr), .doneValid(doneValid),
    .doneAddr(doneAddr), .doneFault(faultOut)
  );

  assign doneFault = faultOut;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int IDX_W = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        cfgValid,
  input logic        cfgIndirect,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [51:0] memReqAddr,
  input logic        doneValid,
  input logic [51:0] doneAddr,
  input logic [1:0]  doneFault
);
  assert_fault_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> doneFault != 2'd3);

  assert_flat_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && cfgValid && !cfgIndirect) |=> (doneValid && !memReqValid));

  assert_fault_clears_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFault != 2'd0) |-> doneAddr == 52'd0);

  assert_invalid_table_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !cfgValid) |=> (doneValid && doneFault == 2'd2 && !memReqValid));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  assert_desc_align_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'd0);
endmodule

bind table_walker tw_checker #(.IDX_W(IDX_W)) chk_i (.*);

// File: tb/table_walker_tb_top.sv
module table_walker_tb_top;
  localparam int IDX_W = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady;
  logic [IDX_W-1:0] reqIndex = '0;
  logic        cfgValid = 1'b0, cfgIndirect = 1'b0;
  logic [1:0]  cfgPageSize = '0;
  logic [4:0]  cfgEntrySizeM1 = '0;
  logic [7:0]  cfgPagesM1 = '0;
  logic [35:0] cfgBaseField = '0;
  logic        memReqValid, memReqReady = 1'b0;
  logic [51:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        doneValid;
  logic [51:0] doneAddr;
  logic [1:0]  doneFault;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  table_walker #(.IDX_W(IDX_W)) dut_i (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic checkEq(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent model of the walk
  typedef struct {
    longint unsigned addr;
    int              fault;
    bit              fetch;
    longint unsigned desc;
    longint unsigned remOff;
    longint unsigned pb;
  } expect_t;

  function automatic expect_t model(longint unsigned idx, bit v, bit ind, int ps,
                                    int es, int pg, longint unsigned bf);
    expect_t r;
    longint unsigned eb, total, base, epp, slot;
    int sh;
    r = '{addr: 0, fault: 0, fetch: 0, desc: 0, remOff: 0, pb: 0};
    sh = (ps == 0) ? 12 : (ps == 1) ? 14 : 16;
    r.pb  = 64'd1 << sh;
    eb    = longint'(es) + 1;
    total = (longint'(pg) + 1) * r.pb;
    base  = (bf << 12) & ~(r.pb - 1);
    if (sh == 16) base = base | ((bf & 64'hF) << 48);
    if (!v) r.fault = 2;
    else if (!ind) begin
      if (idx * eb >= total) r.fault = 1;
      else r.addr = base + idx * eb;
    end else begin
      epp  = r.pb / eb;
      slot = idx / epp;
      if (slot * 8 >= total) r.fault = 1;
      else begin
        r.fetch  = 1;
        r.desc   = base + slot * 8;
        r.remOff = (idx % epp) * eb;
      end
    end
    return r;
  endfunction

  task automatic runWalk(string req, longint unsigned idx, bit v, bit ind, int ps,
                         int es, int pg, longint unsigned bf, logic [63:0] data, int delay);
    expect_t e;
    longint unsigned finalAddr;
    e = model(idx, v, ind, ps, es, pg, bf);
    @(negedge clk);
    checkEq("R7", "reqReady idle", reqReady, 1);
    reqValid = 1'b1; reqIndex = IDX_W'(idx); cfgValid = v; cfgIndirect = ind;
    cfgPageSize = 2'(ps); cfgEntrySizeM1 = 5'(es); cfgPagesM1 = 8'(pg); cfgBaseField = 36'(bf);
    @(negedge clk);
    reqValid = 1'b0;
    // scramble configuration: the walk must use what it captured
    cfgPageSize = 2'($urandom); cfgEntrySizeM1 = 5'($urandom);
    cfgBaseField = {4'($urandom), 32'($urandom)};
    if (!e.fetch) begin
      checkEq(req, "doneValid", doneValid, 1);
      checkEq(req, "doneFault", doneFault, e.fault);
      checkEq(req, "doneAddr", doneAddr, e.addr);
      checkEq(req, "no memReqValid", memReqValid, 0);
    end else begin
      checkEq("R7", "memReqValid", memReqValid, 1);
      checkEq("R7", "memReqAddr", memReqAddr, e.desc);
      checkEq("R7", "reqReady busy", reqReady, 0);
      for (int k = 0; k < delay; k++) begin
        @(negedge clk);
        checkEq("R7", "memReqValid held", memReqValid, 1);
        checkEq("R7", "memReqAddr held", memReqAddr, e.desc);
      end
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      checkEq("R7", "memReqValid dropped", memReqValid, 0);
      memRspValid = 1'b1; memRspData = data;
      @(negedge clk);
      memRspValid = 1'b0; memRspData = {$urandom, $urandom};
      if (data[63]) finalAddr = ((longint'(data) & 64'hF_FFFF_FFFF_FFFF) & ~(e.pb - 1)) + e.remOff;
      else finalAddr = 0;
      checkEq(data[63] ? req : "R9", "doneValid", doneValid, 1);
      checkEq(data[63] ? req : "R9", "doneFault", doneFault, data[63] ? 0 : 2);
      checkEq(data[63] ? req : "R9", "doneAddr", doneAddr, finalAddr);
    end
    @(negedge clk);
    checkEq(req, "doneValid pulse ends", doneValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    checkEq("R1", "reqReady in reset", reqReady, 1);
    checkEq("R1", "doneValid in reset", doneValid, 0);
    checkEq("R1", "memReqValid in reset", memReqValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "reqReady after reset", reqReady, 1);
    checkEq("R1", "doneValid after reset", doneValid, 0);

    // directed corners
    runWalk("R2", 0, 1, 0, 0, 7, 0, 36'h123456789, '0, 0);
    runWalk("R2", 0, 1, 0, 1, 7, 0, 36'h123456789, '0, 0);
    runWalk("R3", 0, 1, 0, 2, 7, 0, 36'hFEDCBA98A, '0, 0);
    runWalk("R3", 0, 1, 0, 3, 7, 0, 36'h0000F0005, '0, 0);
    runWalk("R4", 5, 1, 0, 0, 15, 2, 36'h000400000, '0, 0);
    runWalk("R4", 511, 1, 0, 0, 7, 0, 36'h000001000, '0, 0);
    runWalk("R5", 512, 1, 0, 0, 7, 0, 36'h000001000, '0, 0);
    runWalk("R6", 3, 0, 0, 0, 7, 0, 36'h000001000, '0, 0);
    runWalk("R6", 3, 0, 1, 0, 7, 0, 36'h000001000, '0, 0);
    runWalk("R8", 262143, 1, 1, 0, 7, 0, 36'h000002000, {1'b1, 11'h0, 52'h0_0000_ABCD_E123}, 2);
    runWalk("R10", 262144, 1, 1, 0, 7, 0, 36'h000002000, '0, 0);
    runWalk("R9", 700, 1, 1, 1, 2, 1, 36'h000100000, {1'b0, 11'h7FF, 52'hF_FFFF_FFFF_FFFF}, 0);
    runWalk("R8", 70000, 1, 1, 2, 23, 3, 36'h12345678B, {1'b1, 11'h5A5, 52'h3_2100_4567_89AB}, 1);

    // constrained random walks
    for (int n = 0; n < 150; n++) begin
      bit v, ind;
      int ps, es, pg, sh, dly;
      longint unsigned bf, idx, pb, cap;
      logic [63:0] data;
      v   = ($urandom % 10) != 0;
      ind = $urandom % 2;
      ps  = $urandom % 4;
      es  = $urandom % 32;
      pg  = $urandom % 4;
      bf  = {4'($urandom), 32'($urandom)};
      sh  = (ps == 0) ? 12 : (ps == 1) ? 14 : 16;
      pb  = 64'd1 << sh;
      if (!ind) cap = ((pg + 1) * pb) / (es + 1);
      else      cap = (((pg + 1) * pb) / 8) * (pb / (es + 1));
      idx = longint'($urandom) % (cap + cap / 8 + 1);
      if (idx >= (64'd1 << IDX_W)) idx = idx % (64'd1 << IDX_W);
      data = {1'(($urandom % 8) != 0), 11'($urandom), 20'($urandom), 32'($urandom)};
      dly  = $urandom % 3;
      runWalk(ind ? "R8" : "R4", idx, v, ind, ps, es, pg, bf, data, dly);
    end

    summary();
    $finish;
  end
endmodule